// File: doc/BRIEF.md
# Serial Shift-and-Add Unsigned Multiplier

This block is the multiply unit of a small 16-bit processor's arithmetic unit. It needs far less area than a single-cycle array multiplier. A start pulse captures two unsigned operands. The block then works through the second operand one bit per clock, lowest bit first. For every set bit it adds the suitably shifted first operand into an accumulator, using one adder that it reuses on every cycle. The block stops once no set bits remain above the current position, so small multipliers finish quickly. The run length depends on the data: it equals the 1-based index of the highest set bit of `b`.

While the block iterates, `busy` tells the control unit to stall the instruction. A one-cycle `done` pulse marks the cycle in which `product` first shows the new result. The result is the low 16 bits of the true product. Bits that overflow are discarded, and no flag reports them.

The interface has no back-pressure. A result is never held up waiting for a consumer. `product` keeps its value until the next operation completes, so a sink may read it late. The only flow-control rule applies to requests: a start is taken only while the block is idle, and a start raised while `busy` is high is dropped.

Top module: `shift_add_mul`

## Requirements
- R1: `product` equals (a × b) mod 2^16, with `a` and `b` being the 16-bit unsigned values captured at the accepted start.
- R2: A `start` sampled while `busy` is high is ignored. The running operation keeps its operands, its latency and its result.
- R3: Overflow is silently truncated and no output reports it. For example, 0xFFFF × 0xFFFF gives 0x0001, and 0x8000 × 2 gives 0x0000.
- R4: Let p be the 1-based position of the highest set bit of `b`, with p = 0 when `b` is zero. `done` is high in the cycle that follows the p-th rising edge after the edge that accepted `start`. A zero `b` therefore gives `done` with `product` = 0 in the very next cycle.
- R5: `busy` is high in every cycle from the one after an accepted start with nonzero `b` up to, but not including, the `done` cycle. It is never high together with `done`, and it never rises for a zero `b`.
- R6: `done` is high for exactly one cycle per completed operation.
- R7: `product` changes only on the edge that raises `done`, and holds steady in all other cycles.
- R8: While reset (`rst_n` low, asynchronous) is applied and just after it, `busy` = 0, `done` = 0 and `product` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only while busy is low |
| a | input | 16 | Multiplicand, unsigned |
| b | input | 16 | Multiplier, unsigned; its highest set bit sets the latency |
| product | output | 16 | Low 16 bits of a × b, held until the next completion |
| busy | output | 1 | Iterations still pending; control unit stalls |
| done | output | 1 | One-cycle pulse: product has just become valid |

## Verification
The bench counts the cycles between an accepted start and `done`. The required count is p, the index of the highest set bit of `b`, so `done` is already high one cycle after start when `b` is zero. Inputs are driven, and outputs sampled, on falling edges. Each counted falling edge therefore comes after exactly one rising edge, and the count compares directly with p. `busy` is checked in every waiting cycle, `done` is checked to have dropped one cycle after it rose, and `product` is checked to stay unchanged over the following idle cycles. The sweeps cover all 5-bit operand pairs, every single-bit multiplier, a pseudo-random set of full-width pairs, the overflow cases and a start raised in the middle of a run.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/sam_adder.sv
// Ripple-carry adder built from a generated full-adder chain; the carry out
// of the top bit is not formed because the product is kept modulo 2^W.
module sam_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  logic [W-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = x[i] ^ y[i] ^ cy[i];
    if (i < W - 1) begin : g_carry
      assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
    end
  end
endmodule

// File: rtl/sam_datapath.sv
// Operand shift registers and accumulator around one shared adder.
module sam_datapath #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] acc_next,
  output logic         last
);
  logic [W-1:0] mcand_q;
  logic [W-1:0] mplier_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] addend;

  // Add the shifted multiplicand only when the current multiplier bit is set.
  assign addend = mplier_q[0] ? mcand_q : '0;

  sam_adder #(.W(W)) u_add (
    .x (acc_q),
    .y (addend),
    .s (acc_next)
  );

  // Nothing left above the bit handled in this cycle: this is the final step.
  assign last = ~|mplier_q[W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load) begin
      mcand_q  <= a;
      mplier_q <= b;
      acc_q    <= '0;
    end else if (step) begin
      acc_q    <= acc_next;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end
endmodule

// File: rtl/sam_ctrl.sv
// Idle/run sequencing, request acceptance and the completion pulse.
module sam_ctrl
  import shift_add_mul_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic b_zero,
  input  logic last,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  phase_t ph_q;
  logic   done_q;

  assign load = start && (ph_q == PH_IDLE);
  assign step = (ph_q == PH_RUN);
  assign busy = step;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= (load && b_zero) || (step && last);
      case (ph_q)
        PH_IDLE: if (load && !b_zero) ph_q <= PH_RUN;
        PH_RUN:  if (last)            ph_q <= PH_IDLE;
        default:                      ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] product,
  output logic         busy,
  output logic         done
);
  logic         load;
  logic         step;
  logic         last;
  logic         b_zero;
  logic [W-1:0] acc_next;
  logic [W-1:0] prod_q;

  assign b_zero = ~|b;

  sam_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .b_zero (b_zero),
    .last   (last),
    .load   (load),
    .step   (step),
    .busy   (busy),
    .done   (done)
  );

  sam_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .a        (a),
    .b        (b),
    .acc_next (acc_next),
    .last     (last)
  );

  // Result register: written only on the edge that completes an operation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                prod_q <= '0;
    else if (load && b_zero)   prod_q <= '0;
    else if (step && last)     prod_q <= acc_next;
  end

  assign product = prod_q;
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] b,
  input logic [W-1:0] product,
  input logic         busy,
  input logic         done
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_excl_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_start_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (b != '0)) |=> busy);

  p_zero_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (b == '0)) |=> (done && (product == '0) && !busy));

  p_fall_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_product_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
endmodule

bind shift_add_mul shift_add_mul_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .b       (b),
  .product (product),
  .busy    (busy),
  .done    (done)
);

// File: tb/tb_shift_add_mul.sv
`timescale 1ns/1ps
module tb_shift_add_mul;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] product;
  logic         busy;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shift_add_mul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .product(product), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int msb_pos(input logic [W-1:0] v);
    int p = 0;
    for (int i = 0; i < W; i++) if (v[i]) p = i + 1;
    return p;
  endfunction

  // Runs one operation; called at a falling edge, returns at a falling edge.
  task automatic run_op(input logic [W-1:0] ia, input logic [W-1:0] ib);
    logic [W-1:0] expp;
    logic [W-1:0] held;
    int n;
    expp = W'((32'(ia) * 32'(ib)) & 32'hFFFF);
    a = ia; b = ib; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      chk(busy == 1'b1, "R5 busy while pending", busy, 1);
      @(negedge clk);
      n++;
    end
    chk(busy == 1'b0, "R5 busy low at done", busy, 0);
    chk(n == msb_pos(ib), "R4 latency", n, msb_pos(ib));
    chk(product == expp, "R1 product", product, expp);
    held = product;
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    @(negedge clk);
    chk(product == held, "R7 product held", product, held);
  endtask

  initial begin
    logic [31:0] lcg;
    int n;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8 reset busy", busy, 0);
    chk(done == 1'b0, "R8 reset done", done, 0);
    chk(product == '0, "R8 reset product", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && product == '0, "R8 after reset", {busy, done}, 0);

    // R1 R4: every pair of 5-bit operands
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        run_op(W'(i), W'(j));

    // R4: each single-bit multiplier against an all-ones multiplicand
    for (int k = 0; k < W; k++) run_op(16'hFFFF, W'(1) << k);

    // R3: truncation without any flag
    run_op(16'hFFFF, 16'hFFFF);
    run_op(16'h8000, 16'h0002);
    run_op(16'h1234, 16'h0000);

    // R1: pseudo-random full-width pairs
    lcg = 32'h1ACE_0001;
    for (int t = 0; t < 300; t++) begin
      logic [W-1:0] ra;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      ra = lcg[31:16];
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run_op(ra, lcg[31:16]);
    end

    // R2: a start in the middle of a run is dropped
    a = 16'h0003; b = 16'h8000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      if (n == 3) begin a = 16'h0005; b = 16'h0001; start = 1'b1; end
      else begin start = 1'b0; a = '0; b = '0; end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == 16, "R2 latency kept", n, 16);
    chk(product == 16'h8000, "R2 result kept", product, 16'h8000);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R2 no second operation", {busy, done}, 0);
    repeat (4) @(negedge clk);
    chk(product == 16'h8000, "R7 held while idle", product, 16'h8000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule